// File: doc/BRIEF.md
# Dual-Bus Serial Slave Front End

This block is the slave side of a peripheral that exposes two logical serial buses over a single clock/data pair. One bus carries register traffic: 32-bit frames framed by an active-low control select, each made of a command byte, a register address byte and a 16-bit value. A write command is turned into a one-cycle register write request when the select is released, and a read command is turned into a read request as soon as the address byte is in. The returned value is shifted out on the serial output during the last 16 clocks of the frame. The other bus carries a plain byte stream, assembled most significant bit first and delivered one byte per strobe.

The byte stream normally listens only while a dedicated data select is low. Writing bit 10 of the register at address 0 turns on a shared-select mode. In that mode the stream listens whenever the control select is high, so the data select pin can be left unused. All serial pins are synchronised into the system clock and sampled on detected edges. Serial clock mode is idle-low, with capture on the rising edge and output change on the falling edge. A ready flag tells the host when another transfer may start.

Top module: `spi_dual_slave`

## Requirements
- R1: A write frame is a command byte 0x02, an address byte and a 16-bit value, all most significant bit first. It produces exactly one `reg_wr` pulse, with `reg_addr` and `reg_wdata` holding the received fields, after the control select rises following exactly 32 clock bits.
- R2: A frame with command byte 0x03 raises `reg_rd` for one cycle after its 16th bit, with `reg_addr` set to the second byte. The value on `reg_rdata` is then presented on `so`, most significant bit first, valid at clock rises 17 to 32.
- R3: A frame that ends after more or fewer than 32 bits produces no write. The bit counter restarts at every falling edge of the control select, so a full frame after an aborted one is decoded normally.
- R4: A frame whose command byte is neither 0x02 nor 0x03 produces no read and no write request.
- R5: `so_oe` is high only during the data phase of a read frame and is low at all other times, including during write frames.
- R6: With shared mode off, clock bits received while `dcs_n` is low and `cs_n` is high are packed into bytes, most significant bit first, and each completed byte gives one `byte_valid` pulse carrying it on `byte_data`.
- R7: With shared mode off, clock bits received while `dcs_n` is high produce no bytes. A partial byte is dropped when the data bus is deselected.
- R8: A committed write to address 0 sets shared mode from bit 10 of the value. While the mode is on, bytes are collected whenever `cs_n` is high, whatever the level of `dcs_n`. Writing the bit back to 0 restores R6 and R7.
- R9: `dreq` is low in the cycle of a `reg_wr` pulse and in the following cycle. It is also low in the cycle after any cycle in which `reg_busy` is high, and high otherwise.
- R10: After reset, `dreq` is high, `so_oe`, `reg_wr`, `reg_rd` and `byte_valid` are low, and shared mode is off.
- R11: While `cs_n` is low, clock bits never reach the byte stream, even when `dcs_n` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data into the block |
| cs_n | input | 1 | Active-low control bus select |
| dcs_n | input | 1 | Active-low data bus select |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for `so` (high drives the pin) |
| reg_busy | input | 1 | Register side still processing a write |
| dreq | output | 1 | High when the block can take a new transfer |
| reg_rd | output | 1 | One-cycle register read request |
| reg_wr | output | 1 | One-cycle register write request |
| reg_addr | output | 8 | Register address of the current request |
| reg_wdata | output | 16 | Register write value |
| reg_rdata | input | 16 | Register read value, stable after `reg_rd` |
| byte_valid | output | 1 | One-cycle strobe for a completed data byte |
| byte_data | output | 8 | Completed data byte |

## Verification
The bench targets frames of 20 and 33 bits. A counter that is not cleared on select fall, or that wraps, would commit these as writes or misalign the following frame. It checks the first read bit on `so` before the 17th rising clock, which a design loading one falling edge late would miss or shift by one bit. It sends a partial byte followed by a reselect, which leaves stale bits in the next byte of a design that keeps its bit counter. It also turns shared mode on and off through address 0. A design routing on the wrong bit, or letting the stream see bits while the control select is low, would emit extra or missing bytes.

// File: rtl/spi_dual_pkg.sv
// Shared constants for the dual-bus serial slave.
// Assumes command codes fit in the command field width chosen by the top.
package spi_dual_pkg;
    localparam int CMD_WRITE = 2;   // register write command code
    localparam int CMD_READ  = 3;   // register read command code
endpackage

// File: rtl/spi_sync.sv
// Multi-bit, multi-stage synchroniser for asynchronous serial pins.
// Assumes each bit is independent (no bus coherency needed) and that
// inputs stay stable for several system clocks between changes.
module spi_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each later stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_frame.sv
// Control-bus frame decoder: shifts in command, address and value bits,
// issues a read request once the header is complete, serialises the read
// value on falling edges, and commits writes on select release.
// Assumes edge strobes are single-cycle and already synchronised.
module spi_ctrl_frame
    import spi_dual_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              sin,
    input  logic              sel_n,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic [DATA_W-1:0] rdata,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              so,
    output logic              so_oe
);
    localparam int HDR_BITS   = CMD_W + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT      = CNT_W'(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] shreg_nxt;
    logic [CNT_W-1:0]      cnt;
    logic                  is_read;
    logic [DATA_W-1:0]     out_sh;
    logic                  oe_q;
    logic [CMD_W-1:0]      hdr_cmd;
    logic [CMD_W-1:0]      frame_cmd;

    // Next shift value and the command byte seen at two frame positions.
    always_comb begin
        shreg_nxt = {shreg[FRAME_BITS-2:0], sin};
        hdr_cmd   = shreg[HDR_BITS-2 -: CMD_W];
        frame_cmd = shreg[FRAME_BITS-1 -: CMD_W];
    end

    // Frame sequencing: count, shift, read launch, output shift, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            is_read  <= 1'b0;
            out_sh   <= '0;
            oe_q     <= 1'b0;
            addr     <= '0;
            wdata    <= '0;
            wr_pulse <= 1'b0;
            rd_pulse <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            rd_pulse <= 1'b0;
            if (sel_fall) begin
                cnt     <= '0;
                is_read <= 1'b0;
                oe_q    <= 1'b0;
            end else if (!sel_n && bit_rise) begin
                shreg <= shreg_nxt;
                if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
                if (cnt == CNT_HDR_LAST && hdr_cmd == CMD_W'(CMD_READ)) begin
                    is_read  <= 1'b1;
                    rd_pulse <= 1'b1;
                    addr     <= shreg_nxt[ADDR_W-1:0];
                end
            end else if (!sel_n && bit_fall && is_read) begin
                if (!oe_q && cnt == CNT_HDR) begin
                    out_sh <= rdata;
                    oe_q   <= 1'b1;
                end else if (oe_q) begin
                    out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                end
            end
            if (sel_rise) begin
                oe_q    <= 1'b0;
                is_read <= 1'b0;
                if (cnt == CNT_FULL && frame_cmd == CMD_W'(CMD_WRITE)) begin
                    wr_pulse <= 1'b1;
                    addr     <= shreg[DATA_W+ADDR_W-1:DATA_W];
                    wdata    <= shreg[DATA_W-1:0];
                end
            end
        end
    end

    assign so    = out_sh[DATA_W-1];
    assign so_oe = oe_q;
endmodule

// File: rtl/spi_data_stream.sv
// Data-bus byte assembler: packs rising-edge bits MSB first into bytes
// and strobes each completed byte. Assumes `active` already folds in
// select routing; a low `active` drops any partial byte.
module spi_data_stream #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              bit_rise,
    input  logic              sin,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_nxt;
    logic [BC_W-1:0]   bcnt;

    // Shift value including the newly sampled bit.
    always_comb sh_nxt = {sh[BYTE_W-2:0], sin};

    // Bit collection and byte strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bcnt       <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!active) begin
                bcnt <= '0;
            end else if (bit_rise) begin
                sh   <= sh_nxt;
                bcnt <= bcnt + BC_W'(1);
                if (bcnt == BC_LAST) begin
                    byte_valid <= 1'b1;
                    byte_data  <= sh_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/spi_dual_slave.sv
// Top of the dual-bus serial slave: synchronises the pins, derives edge
// strobes, routes bits to the control decoder or the byte stream, keeps
// the shared-select mode bit, and drives the ready flag.
// Assumes the system clock is at least 8x the serial clock.
module spi_dual_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int CMD_W       = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int MODE_ADDR   = 0,
    parameter int SHARE_BIT   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              si,
    input  logic              cs_n,
    input  logic              dcs_n,
    output logic              so,
    output logic              so_oe,
    input  logic              reg_busy,
    output logic              dreq,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int PIN_W = 4;
    localparam logic [PIN_W-1:0] PIN_RST = 4'b0011; // sclk low, selects high

    logic [PIN_W-1:0] pins_s;
    logic sclk_s, si_s, csn_s, dcsn_s;
    logic sclk_q, csn_q;
    logic bit_rise, bit_fall, sel_fall, sel_rise;
    logic share_q, dreq_q, data_active;

    spi_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, si, cs_n, dcs_n}),
        .dout (pins_s)
    );

    assign {sclk_s, si_s, csn_s, dcsn_s} = pins_s;

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    // Edge strobes and data-bus routing.
    always_comb begin
        bit_rise    = sclk_s & ~sclk_q;
        bit_fall    = ~sclk_s & sclk_q;
        sel_fall    = csn_q & ~csn_s;
        sel_rise    = ~csn_q & csn_s;
        data_active = csn_s & (share_q | ~dcsn_s);
    end

    spi_ctrl_frame #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_rise(bit_rise),
        .bit_fall(bit_fall),
        .sin     (si_s),
        .sel_n   (csn_s),
        .sel_fall(sel_fall),
        .sel_rise(sel_rise),
        .rdata   (reg_rdata),
        .wr_pulse(reg_wr),
        .rd_pulse(reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .so      (so),
        .so_oe   (so_oe)
    );

    spi_data_stream #(.BYTE_W(BYTE_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (data_active),
        .bit_rise  (bit_rise),
        .sin       (si_s),
        .byte_valid(byte_valid),
        .byte_data (byte_data)
    );

    // Shared-select mode follows committed writes to the mode address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            share_q <= 1'b0;
        else if (reg_wr && reg_addr == ADDR_W'(MODE_ADDR))
            share_q <= reg_wdata[SHARE_BIT];
    end

    // Ready flag: held low one cycle past a commit or a busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dreq_q <= 1'b1;
        else        dreq_q <= ~(reg_busy | reg_wr);
    end

    assign dreq = dreq_q & ~reg_wr;
endmodule

// File: rtl/spi_dual_slave_chk.sv
// Protocol checker for the dual-bus serial slave, bound to every instance.
// Assumes synchronous active-low reset held from time zero.
module spi_dual_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_rd,
    input logic reg_busy,
    input logic dreq,
    input logic so_oe,
    input logic byte_valid
);
    assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd}));

    assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !reg_wr);

    assert_byte_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_dreq_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !dreq);

    assert_dreq_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_busy |=> !dreq);
endmodule

bind spi_dual_slave spi_dual_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_busy  (reg_busy),
    .dreq      (dreq),
    .so_oe     (so_oe),
    .byte_valid(byte_valid)
);

// File: tb/spi_dual_slave_test.sv
module spi_dual_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;      // system clocks per serial half period
    localparam int NV         = 6;
    // {kind, frame}: kind 0 = write, 1 = read, 2 = ignored command
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 32'h0207_C012},
        {2'd1, 32'h0307_0000},
        {2'd0, 32'h023C_5AA5},
        {2'd1, 32'h03A1_FFFF},
        {2'd2, 32'h0510_1234},
        {2'd0, 32'h02FF_0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, si = 1'b0, cs_n = 1'b1, dcs_n = 1'b1, reg_busy = 1'b0;
    logic so, so_oe, dreq, reg_rd, reg_wr, byte_valid;
    logic [7:0]  reg_addr, byte_data;
    logic [15:0] reg_wdata, reg_rdata;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, byte_cnt = 0;
    logic [7:0]  last_addr;
    logic [15:0] last_wdata;
    logic [7:0]  byte_log [32];
    int dreq_follow = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = {reg_addr, ~reg_addr};   // register model

    spi_dual_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .si(si), .cs_n(cs_n), .dcs_n(dcs_n),
        .so(so), .so_oe(so_oe), .reg_busy(reg_busy), .dreq(dreq),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .byte_valid(byte_valid), .byte_data(byte_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Event monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dreq_follow == 2) begin
                check(dreq == 1'b0, "R9 dreq low cycle after commit", {31'd0, dreq}, 32'd0);
                dreq_follow = 1;
            end else if (dreq_follow == 1) begin
                check(dreq == 1'b1, "R9 dreq back high", {31'd0, dreq}, 32'd1);
                dreq_follow = 0;
            end
            if (reg_wr) begin
                wr_cnt++;
                last_addr  = reg_addr;
                last_wdata = reg_wdata;
                check(dreq == 1'b0, "R9 dreq low in commit cycle", {31'd0, dreq}, 32'd0);
                dreq_follow = 2;
            end
            if (reg_rd) rd_cnt++;
            if (byte_valid) begin
                if (byte_cnt < 32) byte_log[byte_cnt] = byte_data;
                byte_cnt++;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: data set while low, clock high for a half period.
    task automatic spi_bit(input logic b);
        si = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] f, input int nbits, output logic [15:0] back);
        logic rd_frame;
        rd_frame = (f[31:24] == 8'h03);
        back = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 32) ? f[31-i] : 1'b0;
            wait_clk(HALF);
            if (i >= 16 && i < 32) back[31-i] = so;
            if (i == 16 || i == 31 || i == 8)
                check(so_oe == (rd_frame && i >= 16), "R5 so_oe during frame",
                      {31'd0, so_oe}, {31'd0, rd_frame && i >= 16});
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) spi_bit(v[7-i]);
        wait_clk(HALF);
    endtask

    initial begin
        logic [15:0] back;
        int w0, r0, b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
        // R10 reset state
        check(dreq == 1'b1, "R10 dreq after reset", {31'd0, dreq}, 32'd1);
        check({so_oe, reg_wr, reg_rd, byte_valid} == 4'b0, "R10 outputs idle after reset",
              {28'd0, so_oe, reg_wr, reg_rd, byte_valid}, 32'd0);

        // Table walk: R1 writes, R2 reads, R4 ignored commands
        for (int k = 0; k < NV; k++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            send_frame(VEC[k][31:0], 32, back);
            case (VEC[k][33:32])
                2'd0: begin
                    check(wr_cnt == w0 + 1 && rd_cnt == r0, "R1 one write request",
                          wr_cnt - w0, 32'd1);
                    check({last_addr, last_wdata} == VEC[k][23:0], "R1 write fields",
                          {8'd0, last_addr, last_wdata}, {8'd0, VEC[k][23:0]});
                end
                2'd1: begin
                    check(rd_cnt == r0 + 1 && wr_cnt == w0, "R2 one read request",
                          rd_cnt - r0, 32'd1);
                    check(back == {VEC[k][23:16], ~VEC[k][23:16]}, "R2 read data on so",
                          {16'd0, back}, {16'd0, VEC[k][23:16], ~VEC[k][23:16]});
                end
                default:
                    check(wr_cnt == w0 && rd_cnt == r0, "R4 unknown command ignored",
                          (wr_cnt - w0) + (rd_cnt - r0), 32'd0);
            endcase
            check(so_oe == 1'b0, "R5 so_oe low between frames", {31'd0, so_oe}, 32'd0);
        end

        // R3 short, long, then recovery
        w0 = wr_cnt;
        send_frame(32'h0211_2222, 20, back);
        check(wr_cnt == w0, "R3 20-bit frame discarded", wr_cnt - w0, 32'd0);
        send_frame(32'h0211_2222, 33, back);
        check(wr_cnt == w0, "R3 33-bit frame discarded", wr_cnt - w0, 32'd0);
        send_frame(32'h0233_4444, 32, back);
        check(wr_cnt == w0 + 1 && last_addr == 8'h33 && last_wdata == 16'h4444,
              "R3 full frame after abort", {last_addr, last_wdata}, 32'h0033_4444);

        // R6 data bytes with dedicated select
        b0 = byte_cnt;
        dcs_n = 1'b0; wait_clk(HALF);
        send_bits(8'hA5, 8);
        send_bits(8'h12, 8);
        dcs_n = 1'b1; wait_clk(HALF);
        check(byte_cnt == b0 + 2, "R6 two bytes", byte_cnt - b0, 32'd2);
        check(byte_log[b0] == 8'hA5 && byte_log[b0+1] == 8'h12, "R6 byte values",
              {16'd0, byte_log[b0], byte_log[b0+1]}, 32'h0000_A512);

        // R7 partial byte dropped on deselect
        b0 = byte_cnt;
        dcs_n = 1'b0; wait_clk(HALF);
        send_bits(8'hF8, 5);
        dcs_n = 1'b1; wait_clk(HALF);
        dcs_n = 1'b0; wait_clk(HALF);
        send_bits(8'h3C, 8);
        dcs_n = 1'b1; wait_clk(HALF);
        check(byte_cnt == b0 + 1 && byte_log[b0] == 8'h3C, "R7 partial byte dropped",
              {24'd0, byte_log[b0]}, 32'h3C);

        // R7 no bytes with both selects high
        b0 = byte_cnt;
        send_bits(8'hFF, 8);
        send_bits(8'h00, 8);
        check(byte_cnt == b0, "R7 no bytes while deselected", byte_cnt - b0, 32'd0);

        // R11 control select has priority over data select
        b0 = byte_cnt; w0 = wr_cnt;
        dcs_n = 1'b0; wait_clk(HALF);
        send_frame(32'h0255_6666, 32, back);
        dcs_n = 1'b1; wait_clk(HALF);
        check(byte_cnt == b0 && wr_cnt == w0 + 1, "R11 no bytes during control frame",
              byte_cnt - b0, 32'd0);

        // R8 shared mode on: address 0, bit 10
        send_frame(32'h0200_0400, 32, back);
        b0 = byte_cnt;
        send_bits(8'h81, 8);
        dcs_n = 1'b0; wait_clk(HALF);
        send_bits(8'h7E, 8);
        dcs_n = 1'b1; wait_clk(HALF);
        check(byte_cnt == b0 + 2 && byte_log[b0] == 8'h81 && byte_log[b0+1] == 8'h7E,
              "R8 bytes with select high in shared mode",
              {16'd0, byte_log[b0], byte_log[b0+1]}, 32'h0000_817E);
        // R8 shared mode off again
        send_frame(32'h0200_0000, 32, back);
        b0 = byte_cnt;
        send_bits(8'h55, 8);
        check(byte_cnt == b0, "R8 shared mode cleared", byte_cnt - b0, 32'd0);

        // R9 busy input
        reg_busy = 1'b1;
        wait_clk(1);
        check(dreq == 1'b0, "R9 dreq low while busy", {31'd0, dreq}, 32'd0);
        reg_busy = 1'b0;
        wait_clk(1);
        check(dreq == 1'b1, "R9 dreq high after busy", {31'd0, dreq}, 32'd1);

        wait_clk(8);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule